// File: doc/BRIEF.md
# Timer Compare Match Output Unit

This unit holds a 16-bit compare value and checks it on every clock against the count of one of two external free-running timers. A select bit picks which timer is the time base. When the selected count equals the compare value, a 4-bit mode field chooses the action:
- the output latch can be set, cleared or toggled;
- the latch can be left alone, with only the interrupt flag raised;
- in the special trigger mode, the selected timer is told to reset, which turns the compare value into a programmable period, and an A/D conversion can be requested.

A small state machine qualifies each match on its leading edge. It has three states:
- `ST_OFF`: the unit is disabled.
- `ST_ARMED`: the unit waits for equality.
- `ST_HELD`: equality has been acted on, and the unit waits for it to go away.

Its transitions are:
- OFF→ARMED: the mode becomes nonzero.
- ARMED→HELD: equality is seen. This transition is the only one that fires the action.
- HELD→ARMED: equality is lost.
- any state→OFF: the mode becomes zero.

A mode write takes effect on the next clock edge. The state machine follows one edge later.

Top module: `cmp_match_unit`

## Requirements
- R1: With `cfg_tsel`=0 the compare value is matched against `tmr_a_cnt`; with `cfg_tsel`=1 it is matched against `tmr_b_cnt`. The timer that is not selected never causes a match.
- R2: The match action fires once, on the first clock edge at which equality is seen while armed. It does not fire again until equality has been absent for at least one cycle.
- R3: Mode 4'b0010 inverts `cmp_latch` at the firing edge.
- R4: Mode 4'b1000 drives `cmp_latch` to 1 on a match. Mode 4'b1001 drives it to 0 on a match.
- R5: Every fired match sets `irq_flag` at the firing edge in every nonzero mode. The flag stays set until `flag_clr` is high at an edge. A match at the same edge wins over the clear.
- R6: Mode 4'b1010 sets `irq_flag` on a match and leaves `cmp_latch` unchanged.
- R7: Mode 4'b1011 pulses, for exactly one cycle after the firing edge, the reset output of the selected timer only: `tmr_a_rst` when `cfg_tsel`=0, `tmr_b_rst` when it is 1.
- R8: `adc_start` pulses for one cycle only for a match in mode 4'b1011, and only if `adc_enabled` is high in the firing cycle.
- R9: A control write with mode 4'b0000 clears `cmp_latch` at that edge and disables matching.
- R10: `pin_out` equals `cmp_latch` when `pin_oe` is high and is 0 otherwise. `cmp_latch` updates whatever the value of `pin_oe`.
- R11: After reset all outputs are 0 and the unit is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control write strobe (mode and timer select) |
| cfg_mode | input | 4 | Mode written on `cfg_we` |
| cfg_tsel | input | 1 | Time base select written on `cfg_we` |
| cmp_we | input | 1 | Compare value write strobe |
| cmp_wdata | input | 16 | Compare value |
| tmr_a_cnt | input | 16 | Count of timer A |
| tmr_b_cnt | input | 16 | Count of timer B |
| adc_enabled | input | 1 | A/D converter is enabled |
| pin_oe | input | 1 | Pin driver enable |
| flag_clr | input | 1 | Write-one-to-clear for `irq_flag` |
| tmr_a_rst | output | 1 | One-cycle reset request to timer A |
| tmr_b_rst | output | 1 | One-cycle reset request to timer B |
| adc_start | output | 1 | One-cycle A/D start strobe |
| irq_flag | output | 1 | Sticky match interrupt flag |
| cmp_latch | output | 1 | Internal compare output latch |
| pin_out | output | 1 | Gated pin drive |

## Verification
If the state machine sticks in `ST_ARMED` while equality persists, the fault shows one cycle after the second equal cycle. A toggle mode inverts `cmp_latch` again, and a special trigger mode repeats the reset or A/D pulse. If the state machine fails to return from `ST_HELD`, the next match does nothing: the latch and flag stay put at the edge where they should change. A wrong timer select or a wrong latch value shows on `cmp_latch`, the pulse outputs and `pin_out` one edge after the equality is applied. The bench therefore samples every check at that edge and at the edge after it.

// File: rtl/cmu_pkg.sv
package cmu_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_HELD  = 2'd2
    } cmu_state_e;

    typedef enum logic [1:0] {
        ACT_KEEP = 2'd0,
        ACT_SET  = 2'd1,
        ACT_CLR  = 2'd2,
        ACT_TOG  = 2'd3
    } cmu_act_e;

    localparam logic [3:0] MODE_OFF     = 4'b0000;
    localparam logic [3:0] MODE_TOGGLE  = 4'b0010;
    localparam logic [3:0] MODE_SET     = 4'b1000;
    localparam logic [3:0] MODE_CLR     = 4'b1001;
    localparam logic [3:0] MODE_IRQ     = 4'b1010;
    localparam logic [3:0] MODE_SPECIAL = 4'b1011;

    function automatic cmu_act_e decode_act(input logic [3:0] m);
        cmu_act_e a;
        case (m)
            MODE_TOGGLE: a = ACT_TOG;
            MODE_SET:    a = ACT_SET;
            MODE_CLR:    a = ACT_CLR;
            default:     a = ACT_KEEP;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/cmu_match.sv
module cmu_match #(
    parameter int CNT_W   = 16,
    parameter int NUM_TMR = 2,
    localparam int SEL_W  = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1
) (
    input  logic [CNT_W-1:0]              cmp_val,
    input  logic [NUM_TMR-1:0][CNT_W-1:0] tmr_cnt,
    input  logic [SEL_W-1:0]              sel,
    output logic                          eq
);
    logic [NUM_TMR-1:0] hit;

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_cmp
        assign hit[i] = (tmr_cnt[i] == cmp_val);
    end

    assign eq = hit[sel];
endmodule

// File: rtl/cmu_fsm.sv
module cmu_fsm
    import cmu_pkg::*;
#(
    parameter int MODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_q,
    input  logic              eq,
    output cmu_state_e        state,
    output logic              fire
);
    cmu_state_e state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        fire     = 1'b0;
        if (mode_q == '0) begin
            state_nx = ST_OFF;
        end else begin
            unique case (state)
                ST_OFF:   state_nx = ST_ARMED;
                ST_ARMED: if (eq) begin
                              state_nx = ST_HELD;
                              fire     = 1'b1;
                          end
                ST_HELD:  if (!eq) state_nx = ST_ARMED;
                default:  state_nx = ST_OFF;
            endcase
        end
    end
endmodule

// File: rtl/cmu_action.sv
module cmu_action
    import cmu_pkg::*;
#(
    parameter int MODE_W  = 4,
    parameter int NUM_TMR = 2,
    localparam int SEL_W  = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire,
    input  logic [MODE_W-1:0]  mode_q,
    input  logic [SEL_W-1:0]   tsel_q,
    input  logic               adc_enabled,
    input  logic               force_low,
    input  logic               flag_clr,
    output logic               latch_q,
    output logic               flag_q,
    output logic [NUM_TMR-1:0] tmr_rst_q,
    output logic               adc_start_q
);
    cmu_act_e act;
    logic     special;

    assign act     = decode_act(mode_q);
    assign special = fire && (mode_q == MODE_SPECIAL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= 1'b0;
        end else if (force_low) begin
            latch_q <= 1'b0;
        end else if (fire) begin
            unique case (act)
                ACT_SET:  latch_q <= 1'b1;
                ACT_CLR:  latch_q <= 1'b0;
                ACT_TOG:  latch_q <= ~latch_q;
                ACT_KEEP: latch_q <= latch_q;
                default:  latch_q <= latch_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (fire)     flag_q <= 1'b1;
        else if (flag_clr) flag_q <= 1'b0;
    end

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_rst
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) tmr_rst_q[i] <= 1'b0;
            else        tmr_rst_q[i] <= special && (tsel_q == SEL_W'(i));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) adc_start_q <= 1'b0;
        else        adc_start_q <= special && adc_enabled;
    end
endmodule

// File: rtl/cmp_match_unit.sv
module cmp_match_unit
    import cmu_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int MODE_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic             cfg_tsel,
    input  logic             cmp_we,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic [CNT_W-1:0] tmr_a_cnt,
    input  logic [CNT_W-1:0] tmr_b_cnt,
    input  logic             adc_enabled,
    input  logic             pin_oe,
    input  logic             flag_clr,
    output logic             tmr_a_rst,
    output logic             tmr_b_rst,
    output logic             adc_start,
    output logic             irq_flag,
    output logic             cmp_latch,
    output logic             pin_out
);
    localparam int NUM_TMR = 2;

    logic [CNT_W-1:0]              cmp_q;
    logic [MODE_W-1:0]             mode_q;
    logic                          tsel_q;
    logic                          eq;
    logic                          fire;
    logic                          force_low;
    logic [NUM_TMR-1:0]            tmr_rst;
    logic [NUM_TMR-1:0][CNT_W-1:0] cnts;
    cmu_state_e                    state;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
            tsel_q <= 1'b0;
        end else if (cfg_we) begin
            mode_q <= cfg_mode;
            tsel_q <= cfg_tsel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cmp_q <= '0;
        else if (cmp_we) cmp_q <= cmp_wdata;
    end

    assign cnts      = {tmr_b_cnt, tmr_a_cnt};
    assign force_low = cfg_we && (cfg_mode == '0);

    cmu_match #(.CNT_W(CNT_W), .NUM_TMR(NUM_TMR)) match_i (
        .cmp_val (cmp_q),
        .tmr_cnt (cnts),
        .sel     (tsel_q),
        .eq      (eq)
    );

    cmu_fsm #(.MODE_W(MODE_W)) fsm_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode_q (mode_q),
        .eq     (eq),
        .state  (state),
        .fire   (fire)
    );

    cmu_action #(.MODE_W(MODE_W), .NUM_TMR(NUM_TMR)) act_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .fire        (fire),
        .mode_q      (mode_q),
        .tsel_q      (tsel_q),
        .adc_enabled (adc_enabled),
        .force_low   (force_low),
        .flag_clr    (flag_clr),
        .latch_q     (cmp_latch),
        .flag_q      (irq_flag),
        .tmr_rst_q   (tmr_rst),
        .adc_start_q (adc_start)
    );

    assign tmr_a_rst = tmr_rst[0];
    assign tmr_b_rst = tmr_rst[1];
    assign pin_out   = pin_oe & cmp_latch;
endmodule

// File: rtl/cmu_chk.sv
module cmu_chk
    import cmu_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_we,
    input logic [3:0] cfg_mode,
    input logic [3:0] mode_q,
    input cmu_state_e state,
    input logic       fire,
    input logic       cmp_latch,
    input logic       irq_flag,
    input logic       tmr_a_rst,
    input logic       tmr_b_rst,
    input logic       adc_start,
    input logic       adc_enabled,
    input logic       pin_oe,
    input logic       pin_out
);
    // R2: one firing per equality episode
    assert_single_fire_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);

    // R9: disabled unit never fires
    assert_off_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF) |-> !fire);

    // R3
    assert_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && mode_q == MODE_TOGGLE && !cfg_we) |=> (cmp_latch != $past(cmp_latch)));

    // R5
    assert_flag_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> irq_flag);

    // R6
    assert_irq_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && mode_q == MODE_IRQ && !cfg_we) |=> $stable(cmp_latch));

    // R7
    assert_rst_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tmr_a_rst || tmr_b_rst) |=> !(tmr_a_rst || tmr_b_rst));

    assert_rst_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tmr_a_rst, tmr_b_rst}));

    // R8
    assert_adc_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_start) |-> $past(adc_enabled && fire && mode_q == MODE_SPECIAL));

    // R9
    assert_force_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_mode == MODE_OFF) |=> !cmp_latch);

    // R10
    always_comb begin
        if (rst_n) begin
            assert_pin_gate_R10: assert (pin_out == (pin_oe && cmp_latch));
        end
    end
endmodule

bind cmp_match_unit cmu_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_mode    (cfg_mode),
    .mode_q      (mode_q),
    .state       (state),
    .fire        (fire),
    .cmp_latch   (cmp_latch),
    .irq_flag    (irq_flag),
    .tmr_a_rst   (tmr_a_rst),
    .tmr_b_rst   (tmr_b_rst),
    .adc_start   (adc_start),
    .adc_enabled (adc_enabled),
    .pin_oe      (pin_oe),
    .pin_out     (pin_out)
);

// File: tb/cmp_match_unit_tb_top.sv
`timescale 1ns/1ps
module cmp_match_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_mode = '0;
    logic        cfg_tsel = 1'b0;
    logic        cmp_we = 1'b0;
    logic [15:0] cmp_wdata = '0;
    logic [15:0] tmr_a_cnt = 16'h1111;
    logic [15:0] tmr_b_cnt = 16'h2222;
    logic        adc_enabled = 1'b0;
    logic        pin_oe = 1'b1;
    logic        flag_clr = 1'b0;
    logic        tmr_a_rst, tmr_b_rst, adc_start, irq_flag, cmp_latch, pin_out;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    cmp_match_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
        .cfg_tsel(cfg_tsel), .cmp_we(cmp_we), .cmp_wdata(cmp_wdata),
        .tmr_a_cnt(tmr_a_cnt), .tmr_b_cnt(tmr_b_cnt), .adc_enabled(adc_enabled),
        .pin_oe(pin_oe), .flag_clr(flag_clr), .tmr_a_rst(tmr_a_rst),
        .tmr_b_rst(tmr_b_rst), .adc_start(adc_start), .irq_flag(irq_flag),
        .cmp_latch(cmp_latch), .pin_out(pin_out)
    );

    // vector: tsel, mode, cmp, ta, tb, adc_en, exp {latch, flag, rsta, rstb, adc}
    localparam int NV = 8;
    localparam logic [58:0] VECS [NV] = '{
        {1'b0, 4'b0010, 16'h1234, 16'h1234, 16'h0000, 1'b0, 5'b11000}, // R1 R3
        {1'b1, 4'b0010, 16'h1234, 16'h1234, 16'h0005, 1'b0, 5'b00000}, // R1
        {1'b1, 4'b1000, 16'hABCD, 16'h0000, 16'hABCD, 1'b0, 5'b11000}, // R4
        {1'b0, 4'b1001, 16'h0000, 16'h0000, 16'h0001, 1'b0, 5'b01000}, // R4
        {1'b0, 4'b1010, 16'h0007, 16'h0007, 16'h0000, 1'b0, 5'b01000}, // R6
        {1'b0, 4'b1011, 16'h0100, 16'h0100, 16'h0000, 1'b1, 5'b01101}, // R7 R8
        {1'b1, 4'b1011, 16'hFFFF, 16'h0000, 16'hFFFF, 1'b0, 5'b01010}, // R7 R8
        {1'b0, 4'b0000, 16'h0055, 16'h0055, 16'h0000, 1'b1, 5'b00000}  // R9
    };

    task automatic chk(input string req, input string what, input logic [15:0] got, input logic [15:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic away();
        tmr_a_cnt = ~dut_cmp;
        tmr_b_cnt = ~dut_cmp;
    endtask

    logic [15:0] dut_cmp = '0;

    task automatic write_cfg(input logic [3:0] m, input logic t);
        cfg_we = 1'b1; cfg_mode = m; cfg_tsel = t;
        step(1);
        cfg_we = 1'b0;
    endtask

    task automatic write_cmp(input logic [15:0] v);
        cmp_we = 1'b1; cmp_wdata = v; dut_cmp = v;
        step(1);
        cmp_we = 1'b0;
    endtask

    // clear latch and flag, set compare, arm with new mode
    task automatic setup(input logic [3:0] m, input logic t, input logic [15:0] c);
        dut_cmp = c; away();
        flag_clr = 1'b1; cmp_we = 1'b1; cmp_wdata = c;
        cfg_we = 1'b1; cfg_mode = 4'b0000; cfg_tsel = t;
        step(1);
        flag_clr = 1'b0; cmp_we = 1'b0; cfg_we = 1'b0;
        step(1);
        write_cfg(m, t);
        step(2);
    endtask

    initial begin
        step(3);
        // R11: reset state
        chk("R11", "latch", 16'(cmp_latch), 0);
        chk("R11", "flag", 16'(irq_flag), 0);
        chk("R11", "pulses", 16'({tmr_a_rst, tmr_b_rst, adc_start, pin_out}), 0);
        rst_n = 1'b1;
        step(2);

        for (int v = 0; v < NV; v++) begin
            logic [58:0] e;
            e = VECS[v];
            setup(e[57:54], e[58], e[53:38]);
            adc_enabled = e[5];
            tmr_a_cnt = e[37:22];
            tmr_b_cnt = e[21:6];
            step(1);
            chk("R1-R9 vec", "latch", 16'(cmp_latch), 16'(e[4]));
            chk("R5 vec", "flag", 16'(irq_flag), 16'(e[3]));
            chk("R7 vec", "rst_a", 16'(tmr_a_rst), 16'(e[2]));
            chk("R7 vec", "rst_b", 16'(tmr_b_rst), 16'(e[1]));
            chk("R8 vec", "adc", 16'(adc_start), 16'(e[0]));
            chk("R10 vec", "pin", 16'(pin_out), 16'(e[4]));
            step(1);
            chk("R2 vec", "latch hold", 16'(cmp_latch), 16'(e[4]));
            chk("R7 vec", "pulses gone", 16'({tmr_a_rst, tmr_b_rst, adc_start}), 0);
            adc_enabled = 1'b0;
        end

        // R2: repeated equality, then re-arm
        setup(4'b0010, 1'b0, 16'h0042);
        tmr_a_cnt = 16'h0042;
        step(4);
        chk("R2", "latch after stall", 16'(cmp_latch), 1);
        away(); step(1);
        tmr_a_cnt = 16'h0042; step(1);
        chk("R2", "latch after rearm", 16'(cmp_latch), 0);

        // R10: pin gated, latch still updates
        away(); pin_oe = 1'b0; step(1);
        tmr_a_cnt = 16'h0042; step(1);
        chk("R10", "latch while gated", 16'(cmp_latch), 1);
        chk("R10", "pin gated", 16'(pin_out), 0);
        pin_oe = 1'b1; step(1);
        chk("R10", "pin enabled", 16'(pin_out), 1);

        // R5: sticky flag, clear, and set-wins
        away(); step(1);
        chk("R5", "flag sticky", 16'(irq_flag), 1);
        flag_clr = 1'b1; step(1); flag_clr = 1'b0;
        chk("R5", "flag cleared", 16'(irq_flag), 0);
        tmr_a_cnt = 16'h0042; flag_clr = 1'b1; step(1); flag_clr = 1'b0;
        chk("R5", "set wins", 16'(irq_flag), 1);

        // R4 and R6: set, then irq-only keeps 1, then low
        setup(4'b1000, 1'b1, 16'h0300);
        tmr_b_cnt = 16'h0300; step(1);
        chk("R4", "set high", 16'(cmp_latch), 1);
        away(); write_cfg(4'b1010, 1'b1); step(1);
        flag_clr = 1'b1; step(1); flag_clr = 1'b0;
        tmr_b_cnt = 16'h0300; step(1);
        chk("R6", "latch kept high", 16'(cmp_latch), 1);
        chk("R6", "flag set", 16'(irq_flag), 1);
        away(); write_cfg(4'b1001, 1'b1); step(1);
        tmr_b_cnt = 16'h0300; step(1);
        chk("R4", "set low", 16'(cmp_latch), 0);

        // R9: mode zero write forces latch low and disables
        away(); write_cfg(4'b1000, 1'b1); step(1);
        tmr_b_cnt = 16'h0300; step(1);
        chk("R9", "latch high before", 16'(cmp_latch), 1);
        away(); write_cfg(4'b0000, 1'b1);
        chk("R9", "forced low", 16'(cmp_latch), 0);
        flag_clr = 1'b1; step(1); flag_clr = 1'b0; step(1);
        tmr_b_cnt = 16'h0300; step(2);
        chk("R9", "no match when off", 16'({cmp_latch, irq_flag}), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        finished = 1'b1;
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule